// File: doc/BRIEF.md
# Single-Channel Microblock DMA Engine

This block is one DMA channel that copies one microblock of data units from a source address to a destination address. Software programs the addresses, the unit count and a configuration word through a small register port, then writes the start bit. The engine reads one unit, writes it, and repeats. Each access is a single beat on a memory port that uses a valid/ready handshake.

In memory-to-memory mode the engine runs without pause. In peripheral-synchronized mode it waits for a request before each chunk. The request comes from a hardware request line or from a software request bit. When the last unit is written, a busy bit drops and an end-of-block status bit is set. That status bit drives an interrupt through two enables, and reading the status clears it.

Register word offsets on `reg_addr_i` are: 0 source address, 1 destination address, 2 length in units (bits [15:0]), 3 configuration, 4 control, 5 interrupt status.

Top module: `ublk_dma`

## Requirements
- R1: After reset, `mem_valid_o` and `irq_o` are 0, and both control bit 0 (busy) and status bit 0 read as 0.
- R2: A length of N makes exactly N source reads and exactly N destination writes.
- R3: A bus request holds its address, write flag and write data until `mem_ready_i` is sampled high. Each unit is read from the source before it is written, and the write carries the data that was read.
- R4: With configuration bit 0 at 0 (memory-to-memory), the whole microblock runs with no request input.
- R5: Configuration bits [2:1] select the unit width: 0 is byte, 1 is halfword, 2 is word. `mem_size_o` carries that code, and an incrementing address steps by 1, 2 or 4.
- R6: Configuration bit 3 selects the source addressing and bit 4 the destination addressing: 1 increments the address, 0 keeps it fixed.
- R7: Writing control bit 0 as 1 sets busy (control read bit 0) from the next cycle. Busy clears in the cycle after the last write is accepted. A start written while busy is ignored.
- R8: On completion, status bit 0 is set. `irq_o` is high only while that bit is 1 and both control bit 1 (block interrupt enable) and control bit 2 (global interrupt enable) are 1.
- R9: A read of the status register returns the pending bit and clears it. If completion falls in the same cycle, the bit stays set.
- R10: A length of 0 completes with no bus access and sets status bit 0.
- R11: With configuration bit 0 at 1 (peripheral mode), no bus access starts until a request is seen.
- R12: In peripheral mode, configuration bits [6:5] give the chunk size: 0 is 1 unit, 1 is 2, 2 is 4, 3 is 8. Each cycle in which a request is seen while waiting moves one chunk, or fewer units if fewer remain.
- R13: In peripheral mode, configuration bit 7 (software request) acts as a request. The hardware clears this bit when it starts a chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears status on read) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| mem_valid_o | output | 1 | Bus request valid |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data, unit in the low lanes |
| mem_size_o | output | 2 | Unit width code |
| mem_ready_i | input | 1 | Bus accepts the request |
| mem_rdata_i | input | DW | Read data, valid with ready on a read |
| per_req_i | input | 1 | Peripheral request line |
| irq_o | output | 1 | End-of-block interrupt |

## Verification
A register write takes effect at the clock edge on which it is sampled, so busy is checked at the next falling edge after the start write. Each bus beat completes on the edge where valid and ready are both high. The monitor samples that pair at the falling edge before the edge and pops one expected address and data item per beat. Completion sets the status bit and clears busy on the same edge, so the bench polls busy and only then reads the status register and `irq_o`. In peripheral mode the bench pulses a request for one cycle and counts beats over a fixed settling window of 40 cycles. That window is longer than the longest chunk under the bench's ready stalls.

// File: rtl/ublk_pkg.sv
package ublk_pkg;
  typedef struct packed {
    logic       periph;
    logic [1:0] width;
    logic       src_inc;
    logic       dst_inc;
    logic [1:0] chunk;
  } xfer_cfg_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_LEN  = 3'd2;
  localparam logic [2:0] REG_CFG  = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  function automatic logic [2:0] step_of(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] chunk_units(input logic [1:0] c);
    return 4'd1 << c;
  endfunction
endpackage

// File: rtl/ublk_regs.sv
module ublk_regs
  import ublk_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          sw_ack_i,
  output logic          start_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output xfer_cfg_t     cfg_o,
  output logic          sw_req_o,
  output logic          blk_ie_o,
  output logic          glb_ie_o,
  output logic          isr_o
);
  logic wr_ctrl, rd_stat;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign rd_stat = re_i && (addr_i == REG_STAT);
  assign start_o = wr_ctrl && wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o    <= '0;
      dst_o    <= '0;
      len_o    <= '0;
      cfg_o    <= '0;
      sw_req_o <= 1'b0;
      blk_ie_o <= 1'b0;
      glb_ie_o <= 1'b0;
      isr_o    <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_SRC) src_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == REG_DST) dst_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == REG_LEN) len_o <= wdata_i[LW-1:0];
      if (we_i && addr_i == REG_CFG) begin
        cfg_o.periph  <= wdata_i[0];
        cfg_o.width   <= wdata_i[2:1];
        cfg_o.src_inc <= wdata_i[3];
        cfg_o.dst_inc <= wdata_i[4];
        cfg_o.chunk   <= wdata_i[6:5];
        sw_req_o      <= wdata_i[7];
      end else if (sw_ack_i) begin
        sw_req_o <= 1'b0;
      end
      if (wr_ctrl) begin
        blk_ie_o <= wdata_i[1];
        glb_ie_o <= wdata_i[2];
      end
      // completion wins over a same-cycle clearing read
      if (done_i)       isr_o <= 1'b1;
      else if (rd_stat) isr_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_SRC:  rdata_o = 32'(src_o);
      REG_DST:  rdata_o = 32'(dst_o);
      REG_LEN:  rdata_o = 32'(len_o);
      REG_CFG:  rdata_o = {24'd0, sw_req_o, cfg_o.chunk, cfg_o.dst_inc,
                           cfg_o.src_inc, cfg_o.width, cfg_o.periph};
      REG_CTRL: rdata_o = {29'd0, glb_ie_o, blk_ie_o, busy_i};
      REG_STAT: rdata_o = {31'd0, isr_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ublk_xfer.sv
module ublk_xfer
  import ublk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  xfer_cfg_t     cfg_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  input  logic          per_req_i,
  input  logic          sw_req_i,
  output logic          sw_ack_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_size_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WAIT, S_RD, S_WR} state_e;

  state_e        state_q;
  xfer_cfg_t     cfg_q;
  logic [AW-1:0] src_q, dst_q, step;
  logic [LW-1:0] rem_q;
  logic [3:0]    chunk_q, grant;
  logic [DW-1:0] data_q;
  logic          trig, beat_done;

  assign step      = AW'(step_of(cfg_q.width));
  assign grant     = (rem_q < LW'(chunk_units(cfg_q.chunk))) ? rem_q[3:0]
                                                              : chunk_units(cfg_q.chunk);
  assign trig      = (state_q == S_WAIT) && (per_req_i || sw_req_i);
  assign sw_ack_o  = (state_q == S_WAIT) && sw_req_i;
  assign beat_done = (state_q == S_WR) && mem_ready_i;
  assign done_o    = ((state_q == S_CHECK) && (rem_q == '0)) ||
                     (beat_done && (rem_q == LW'(1)));
  assign busy_o      = (state_q != S_IDLE);
  assign mem_valid_o = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = (state_q == S_WR) ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign mem_size_o  = cfg_q.width;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          cfg_q <= cfg_i;
          if (cfg_i.width == 2'd3) cfg_q.width <= 2'd2;
          src_q   <= src_i;
          dst_q   <= dst_i;
          rem_q   <= len_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (rem_q == '0)       state_q <= S_IDLE;
          else if (cfg_q.periph) state_q <= S_WAIT;
          else                   state_q <= S_RD;
        end
        S_WAIT: if (trig) begin
          chunk_q <= grant;
          state_q <= S_RD;
        end
        S_RD: if (mem_ready_i) begin
          data_q  <= mem_rdata_i;
          state_q <= S_WR;
        end
        S_WR: if (mem_ready_i) begin
          if (cfg_q.src_inc) src_q <= src_q + step;
          if (cfg_q.dst_inc) dst_q <= dst_q + step;
          rem_q   <= rem_q - LW'(1);
          chunk_q <= chunk_q - 4'd1;
          if (rem_q == LW'(1))                        state_q <= S_IDLE;
          else if (cfg_q.periph && chunk_q == 4'd1)   state_q <= S_WAIT;
          else                                        state_q <= S_RD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ublk_dma.sv
module ublk_dma
  import ublk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_size_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          per_req_i,
  output logic          irq_o
);
  logic          start, busy, done, sw_req, sw_ack, blk_ie, glb_ie, isr;
  logic [AW-1:0] src, dst;
  logic [LW-1:0] len;
  xfer_cfg_t     cfg;

  ublk_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .sw_ack_i(sw_ack),
    .start_o(start), .src_o(src), .dst_o(dst), .len_o(len), .cfg_o(cfg),
    .sw_req_o(sw_req), .blk_ie_o(blk_ie), .glb_ie_o(glb_ie), .isr_o(isr)
  );

  ublk_xfer #(.AW(AW), .DW(DW), .LW(LW)) u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .cfg_i(cfg), .src_i(src), .dst_i(dst), .len_i(len),
    .per_req_i, .sw_req_i(sw_req), .sw_ack_o(sw_ack),
    .busy_o(busy), .done_o(done),
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_size_o,
    .mem_ready_i, .mem_rdata_i
  );

  assign irq_o = isr && blk_ie && glb_ie;
endmodule

// File: rtl/ublk_dma_chk.sv
module ublk_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          done_i,
  input logic          isr_i,
  input logic          valid_i,
  input logic          ready_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [1:0]    size_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(addr_i) && $stable(we_i) && $stable(wdata_i)); // R3
  AST_IDLE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !valid_i); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i); // R7
  AST_DONE_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> isr_i); // R8
  AST_SIZE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(size_i)); // R5
endmodule

bind ublk_dma ublk_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .done_i(done), .isr_i(isr),
  .valid_i(mem_valid_o), .ready_i(mem_ready_i), .we_i(mem_we_o),
  .addr_i(mem_addr_o), .wdata_i(mem_wdata_o), .size_i(mem_size_o)
);

// File: tb/tb_ublk_dma.sv
module tb_ublk_dma;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 0, reg_re = 0, per_req = 0, mem_ready = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_valid, mem_we, irq;
  logic [1:0]  mem_size;
  logic [7:0]  mem [256];
  logic [7:0]  img [256];
  logic [7:0]  ma;
  int          vec_cnt = 0, err_cnt = 0, acc_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [31:0] exp_rd[$], exp_wa[$], exp_wd[$], exp_sz[$];
  logic [31:0] ie_bits = 32'd6;

  always #10 clk = ~clk;

  ublk_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_size_o(mem_size), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .per_req_i(per_req), .irq_o(irq)
  );

  assign ma = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ma+3)], mem[8'(ma+2)], mem[8'(ma+1)], mem[ma]};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model with stalls
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= mem_valid && !mem_ready && (cyc % 3 != 1);
    if (mem_valid && mem_ready && mem_we) begin
      mem[ma] <= mem_wdata[7:0];
      if (mem_size != 2'd0) mem[8'(ma+1)] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[8'(ma+2)] <= mem_wdata[23:16];
        mem[8'(ma+3)] <= mem_wdata[31:24];
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      acc_cnt++;
      if (mem_we) begin
        logic [31:0] m;
        wr_cnt++;
        if (exp_wa.size() == 0) chk(0, "R2 unexpected write", mem_addr, 0);
        else begin
          m = (exp_sz[0] == 0) ? 32'hFF : (exp_sz[0] == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
          chk(mem_addr == exp_wa[0], "R6 write addr", mem_addr, exp_wa[0]);
          chk((mem_wdata & m) == exp_wd[0], "R3 write data", mem_wdata & m, exp_wd[0]);
          chk(32'(mem_size) == exp_sz[0], "R5 size code", 32'(mem_size), exp_sz[0]);
          void'(exp_wa.pop_front()); void'(exp_wd.pop_front()); void'(exp_sz.pop_front());
        end
      end else begin
        if (exp_rd.size() == 0) chk(0, "R2 unexpected read", mem_addr, 0);
        else begin
          chk(mem_addr == exp_rd[0], "R6 read addr", mem_addr, exp_rd[0]);
          void'(exp_rd.pop_front());
        end
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1; #2; d = reg_rdata;
    @(posedge clk); @(negedge clk); reg_re = 0;
  endtask

  task automatic push_xfer(input int src, input int dst, input int len, input int w,
                           input bit si, input bit di);
    int st = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    for (int k = 0; k < len; k++) begin
      logic [7:0]  sa = 8'(src + (si ? k * st : 0));
      logic [31:0] d  = {img[8'(sa+3)], img[8'(sa+2)], img[8'(sa+1)], img[sa]};
      exp_rd.push_back(32'(sa));
      exp_wa.push_back(32'(dst + (di ? k * st : 0)));
      exp_wd.push_back((w == 0) ? (d & 32'hFF) : (w == 1) ? (d & 32'hFFFF) : d);
      exp_sz.push_back(32'(w));
    end
  endtask

  task automatic start(input int src, input int dst, input int len, input logic [31:0] cfg);
    reg_wr(3'd0, 32'(src)); reg_wr(3'd1, 32'(dst));
    reg_wr(3'd2, 32'(len)); reg_wr(3'd3, cfg);
    reg_wr(3'd4, ie_bits | 32'd1);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    int n = 0;
    do begin reg_rd(3'd4, d); n++; end while (d[0] && n < 2000);
    chk(d[0] == 1'b0, tag, d, 0);
  endtask

  task automatic run_m2m(input int src, input int dst, input int len, input int w,
                         input bit si, input bit di, input string tag);
    logic [31:0] d;
    int w0 = wr_cnt;
    push_xfer(src, dst, len, w, si, di);
    start(src, dst, len, 32'((w << 1) | (int'(si) << 3) | (int'(di) << 4)));
    wait_idle({tag, " R4 completes without request"});
    chk(wr_cnt - w0 == len, {tag, " R2 write count"}, 32'(wr_cnt - w0), 32'(len));
    chk(exp_wa.size() == 0 && exp_rd.size() == 0, {tag, " R2 all beats seen"},
        32'(exp_wa.size()), 0);
    reg_rd(3'd5, d);
    chk(d[0] == 1'b1, {tag, " R8 status set"}, d, 1);
  endtask

  task automatic pulse_req(input int exp_units, input string tag);
    int w0 = wr_cnt;
    @(negedge clk); per_req = 1; @(negedge clk); per_req = 0;
    repeat (40) @(negedge clk);
    chk(wr_cnt - w0 == exp_units, tag, 32'(wr_cnt - w0), 32'(exp_units));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int a0, w0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      img[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(mem_valid == 0, "R1 no request", 32'(mem_valid), 0);
    chk(irq == 0, "R1 irq low", 32'(irq), 0);
    reg_rd(3'd4, d); chk(d[0] == 0, "R1 busy clear", d, 0);
    reg_rd(3'd5, d); chk(d[0] == 0, "R1 status clear", d, 0);

    // word, both incrementing; R7 busy after start
    push_xfer(0, 8'h80, 4, 2, 1, 1);
    start(0, 8'h80, 4, 32'h1C);
    reg_rd(3'd4, d); chk(d[0] == 1, "R7 busy set", d, 1);
    wait_idle("R7 busy cleared");
    chk(wr_cnt == 4, "R2 four units", 32'(wr_cnt), 4);
    chk(irq == 1, "R8 irq with both enables", 32'(irq), 1);
    reg_rd(3'd5, d); chk(d[0] == 1, "R9 status read", d, 1);
    reg_rd(3'd5, d); chk(d[0] == 0, "R9 cleared by read", d, 0);
    chk(irq == 0, "R8 irq drops", 32'(irq), 0);

    // byte, source fixed; halfword, destination fixed
    run_m2m(8'h20, 8'hA0, 3, 0, 0, 1, "R5 R6 byte src-fixed");
    run_m2m(8'h10, 8'hC0, 3, 1, 1, 0, "R5 R6 half dst-fixed");

    // R8 masking by global enable
    ie_bits = 32'd2;
    push_xfer(8'h30, 8'hD0, 1, 2, 1, 1);
    start(8'h30, 8'hD0, 1, 32'h1C);
    wait_idle("R7 idle");
    chk(irq == 0, "R8 irq masked by global enable", 32'(irq), 0);
    ie_bits = 32'd6;
    reg_wr(3'd4, ie_bits);
    chk(irq == 1, "R8 irq after global enable", 32'(irq), 1);
    reg_rd(3'd5, d);

    // R10 zero length
    a0 = acc_cnt;
    start(0, 8'hE0, 0, 32'h1C);
    wait_idle("R10 idle");
    chk(acc_cnt == a0, "R10 no bus access", 32'(acc_cnt - a0), 0);
    reg_rd(3'd5, d); chk(d[0] == 1, "R10 status set", d, 1);

    // peripheral mode, hardware request, chunk 2 units, length 5
    push_xfer(8'h40, 8'h80, 5, 2, 1, 1);
    start(8'h40, 8'h80, 5, 32'h3D);
    a0 = acc_cnt;
    repeat (40) @(negedge clk);
    chk(acc_cnt == a0, "R11 no access before request", 32'(acc_cnt - a0), 0);
    pulse_req(2, "R12 chunk of 2");
    pulse_req(2, "R12 chunk of 2 again");
    pulse_req(1, "R12 truncated last chunk");
    wait_idle("R12 idle");
    reg_rd(3'd5, d); chk(d[0] == 1, "R12 status set", d, 1);

    // software request, chunk 1, length 3
    push_xfer(8'h50, 8'hB0, 3, 2, 1, 1);
    start(8'h50, 8'hB0, 3, 32'h1D);
    w0 = wr_cnt;
    repeat (30) @(negedge clk);
    chk(wr_cnt == w0, "R11 waits for request", 32'(wr_cnt - w0), 0);
    for (int k = 0; k < 3; k++) begin
      w0 = wr_cnt;
      reg_wr(3'd3, 32'h9D);
      repeat (30) @(negedge clk);
      chk(wr_cnt - w0 == 1, "R13 software request moves a chunk", 32'(wr_cnt - w0), 1);
      reg_rd(3'd3, d); chk(d[7] == 0, "R13 request bit cleared", d, 0);
    end
    wait_idle("R13 idle");
    reg_rd(3'd5, d); chk(d[0] == 1, "R13 status set", d, 1);
    chk(exp_wa.size() == 0, "R2 queue drained", 32'(exp_wa.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule